// File: doc/BRIEF.md
# Oscillator Start-up Wait Gate

This block withholds the "clock usable" indication of each of two oscillators, one internal and one high-speed, until that oscillator has run for a programmable number of its own cycles after being switched on. A clock that is still settling therefore never reaches the clock source selector. Each oscillator has a private counter clocked by the oscillator itself. The counter is held in reset while the oscillator is off and releases synchronously to the oscillator clock when the oscillator is switched on. Its terminal flag crosses into the system clock domain through a two-flop synchronizer.

Software drives the block through one control byte. The byte holds an on/off bit for each oscillator and a 2-bit wait selector for each. The selectors use inverted encodings: the highest code gives the shortest wait. The oscillator enables are driven out of the block to the oscillator cells. The per-oscillator ready flags go to the clock source selector.

Top module: `osc_wait_gate`

## Requirements
- R1: After reset the control byte reads 0x04: both wait selectors are 0, the internal oscillator is on and the high-speed oscillator is off. Both ready flags are low.
- R2: A write stores the control byte on the next system clock edge. Bits 7:6 hold the internal wait selector, bits 5:4 the high-speed wait selector, bit 2 the internal on bit and bit 0 the high-speed on bit. ctl_rdata returns the stored value with bits 3 and 1 reading 0. int_osc_en and hs_osc_en follow bits 2 and 0.
- R3: Internal oscillator wait length by selector: 3 gives 8 cycles, 2 gives 16, 1 gives 32 and 0 gives 64.
- R4: High-speed oscillator wait length by selector: 3 gives 128 cycles, 2 gives 256, 1 gives 512 and 0 gives 1024.
- R5: Once an oscillator's on bit is set, its local ready is set on the (N+2)th rising edge of that oscillator's clock, where N is the wait length. Two edges release the local reset and N edges are counted. The system-side ready flag rises on the second system clock edge after that.
- R6: Clearing an oscillator's on bit drops its ready flag from the same system edge that stores the write, and discards the count. Setting the bit again, even after only one cycle off, restarts the full wait.
- R7: A start-up uses the selector value stored in the cycle before the on bit was set. A selector written while the oscillator is on, or in the same write that turns it on, applies only to the next start-up.
- R8: Straight after reset release the internal oscillator counts a 64-cycle wait with no write needed.
- R9: The two oscillators are independent: switching one, or changing its selector, never changes the other's ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low reset, asynchronous assert, released in step with sys_clk |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write value |
| ctl_rdata | output | 8 | Stored control byte |
| int_osc_clk | input | 1 | Internal oscillator output clock |
| hs_osc_clk | input | 1 | High-speed oscillator output clock |
| int_osc_en | output | 1 | Internal oscillator on |
| hs_osc_en | output | 1 | High-speed oscillator on |
| int_osc_ready | output | 1 | Internal oscillator settled, system clock domain |
| hs_osc_ready | output | 1 | High-speed oscillator settled, system clock domain |

## Verification
The bench uses the default shortest waits: 8 cycles for the internal oscillator and 128 for the high-speed one. With these defaults every selector code on both oscillators, including the longest 1024-cycle wait, fits in a short run. The oscillator clocks are placed so that none of their edges ever coincides with a system edge. That makes the latency in R5 deterministic, so the bench can predict the exact system cycle in which each ready flag rises and compare it every cycle. The off/on glitch, the selector change during a count and the selector change in the same write as the enable are all exercised against that exact timing.

// File: rtl/osc_wait_pkg.sv
package osc_wait_pkg;
  localparam int SEL_W       = 2;
  localparam int SEL_MAX     = (1 << SEL_W) - 1;
  localparam int OSC_N       = 2;
  localparam int IDX_INT     = 0;
  localparam int IDX_HS      = 1;
  localparam int INT_SEL_LSB = 6;
  localparam int HS_SEL_LSB  = 4;
  localparam int INT_EN_BIT  = 2;
  localparam int HS_EN_BIT   = 0;
  localparam logic [7:0] RD_MASK  = 8'hF5;
  localparam logic [7:0] RST_BYTE = 8'h04;

  typedef logic [SEL_W-1:0] wait_sel_t;
endpackage

// File: rtl/osc_wait_ctl.sv
module osc_wait_ctl
  import osc_wait_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [7:0]                  wdata,
  output logic [7:0]                  rdata,
  output logic [OSC_N-1:0]            en_o,
  output logic [OSC_N-1:0][SEL_W-1:0] snap_o
);
  logic [OSC_N-1:0][SEL_W-1:0] sel_q, sel_d, snap_q, snap_d;
  logic [OSC_N-1:0]            en_q, en_d;
  logic                        unused_wbits;

  assign unused_wbits = ^{wdata[3], wdata[1]};

  always_comb begin
    sel_d = sel_q;
    en_d  = en_q;
    if (wr_en) begin
      sel_d[IDX_INT] = wdata[INT_SEL_LSB +: SEL_W];
      sel_d[IDX_HS]  = wdata[HS_SEL_LSB +: SEL_W];
      en_d[IDX_INT]  = wdata[INT_EN_BIT];
      en_d[IDX_HS]   = wdata[HS_EN_BIT];
    end
  end

  // Selector copy follows the register only while the oscillator is off
  for (genvar g = 0; g < OSC_N; g++) begin : g_snap
    always_comb snap_d[g] = en_q[g] ? snap_q[g] : sel_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      en_q   <= OSC_N'(1 << IDX_INT);
      snap_q <= '0;
    end else begin
      sel_q  <= sel_d;
      en_q   <= en_d;
      snap_q <= snap_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[INT_SEL_LSB +: SEL_W] = sel_q[IDX_INT];
    rdata[HS_SEL_LSB +: SEL_W]  = sel_q[IDX_HS];
    rdata[INT_EN_BIT]           = en_q[IDX_INT];
    rdata[HS_EN_BIT]            = en_q[IDX_HS];
  end

  assign en_o   = en_q;
  assign snap_o = snap_q;

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata == ($past(wdata) & RD_MASK)));

  // R7
  int_snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[IDX_INT] |=> $stable(snap_q[IDX_INT]));

  // R7
  hs_snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q[IDX_HS] |=> $stable(snap_q[IDX_HS]));
endmodule

// File: rtl/osc_start_count.sv
module osc_start_count
  import osc_wait_pkg::*;
#(
  parameter int MIN_LOG = 3
) (
  input  logic      osc_clk,
  input  logic      arst_n,
  input  wait_sel_t sel_i,
  output logic      ready_o
);
  localparam int CNT_W = MIN_LOG + SEL_MAX + 1;

  logic [1:0]       rs_q;
  logic [CNT_W-1:0] cnt_q, cnt_d, len;
  logic             rdy_q, rdy_d, cnt_en;

  // Inverted encoding: highest selector gives the shortest wait
  always_comb len = CNT_W'(1) << (MIN_LOG + SEL_MAX - int'(sel_i));

  assign cnt_en = rs_q[1] & ~rdy_q;

  always_comb begin
    cnt_d = cnt_q;
    rdy_d = rdy_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (cnt_q == len - CNT_W'(1)) rdy_d = 1'b1;
    end
  end

  always_ff @(posedge osc_clk or negedge arst_n) begin
    if (!arst_n) begin
      rs_q  <= '0;
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else begin
      rs_q  <= {rs_q[0], 1'b1};
      cnt_q <= cnt_d;
      rdy_q <= rdy_d;
    end
  end

  assign ready_o = rdy_q;

  // R5
  ready_at_len_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    rdy_q |-> (cnt_q == len));

  // R5
  no_overflow_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    cnt_q <= len);

  // R5
  count_after_release_chk: assert property (@(posedge osc_clk) disable iff (!arst_n)
    !rs_q[1] |=> (cnt_q == '0));
endmodule

// File: rtl/osc_ready_sync.sv
module osc_ready_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic rdy_async_i,
  output logic ready_o
);
  logic [1:0] s_q, s_d;

  always_comb s_d = en_i ? {s_q[0], rdy_async_i} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= 2'b00;
    else        s_q <= s_d;
  end

  assign ready_o = s_q[1] & en_i;

  // R6
  rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> ($past(en_i) && $past(en_i, 2)));

  // R6
  off_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !ready_o);
endmodule

// File: rtl/osc_wait_gate.sv
module osc_wait_gate
  import osc_wait_pkg::*;
#(
  parameter int INT_MIN_LOG = 3,
  parameter int HS_MIN_LOG  = 7
) (
  input  logic       sys_clk,
  input  logic       sys_rst_n,
  input  logic       ctl_wr_en,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       int_osc_clk,
  input  logic       hs_osc_clk,
  output logic       int_osc_en,
  output logic       hs_osc_en,
  output logic       int_osc_ready,
  output logic       hs_osc_ready
);
  logic [OSC_N-1:0]            en, osc_clk, osc_rdy, sys_rdy, osc_arst_n;
  logic [OSC_N-1:0][SEL_W-1:0] snap;

  assign osc_clk[IDX_INT] = int_osc_clk;
  assign osc_clk[IDX_HS]  = hs_osc_clk;

  osc_wait_ctl u_ctl (
    .clk    (sys_clk),
    .rst_n  (sys_rst_n),
    .wr_en  (ctl_wr_en),
    .wdata  (ctl_wdata),
    .rdata  (ctl_rdata),
    .en_o   (en),
    .snap_o (snap)
  );

  for (genvar g = 0; g < OSC_N; g++) begin : g_osc
    localparam int MIN_LOG = (g == IDX_INT) ? INT_MIN_LOG : HS_MIN_LOG;

    // Off bit or system reset holds the oscillator-side counter cleared
    assign osc_arst_n[g] = sys_rst_n & en[g];

    osc_start_count #(.MIN_LOG(MIN_LOG)) u_cnt (
      .osc_clk (osc_clk[g]),
      .arst_n  (osc_arst_n[g]),
      .sel_i   (snap[g]),
      .ready_o (osc_rdy[g])
    );

    osc_ready_sync u_sync (
      .clk         (sys_clk),
      .rst_n       (sys_rst_n),
      .en_i        (en[g]),
      .rdy_async_i (osc_rdy[g]),
      .ready_o     (sys_rdy[g])
    );
  end

  assign int_osc_en    = en[IDX_INT];
  assign hs_osc_en     = en[IDX_HS];
  assign int_osc_ready = sys_rdy[IDX_INT];
  assign hs_osc_ready  = sys_rdy[IDX_HS];
endmodule

// File: tb/tb_osc_wait_gate.sv
`timescale 1ns/1ps
module tb_osc_wait_gate;
  logic       sys_clk, rst_n, wr_en;
  logic [7:0] wdata, rdata;
  logic       int_clk, hs_clk;
  logic       int_en, hs_en, int_rdy, hs_rdy;

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 0;
  string cur_req  = "R1";
  logic [7:0] ctl;

  osc_wait_gate dut (
    .sys_clk(sys_clk), .sys_rst_n(rst_n), .ctl_wr_en(wr_en), .ctl_wdata(wdata),
    .ctl_rdata(rdata), .int_osc_clk(int_clk), .hs_osc_clk(hs_clk),
    .int_osc_en(int_en), .hs_osc_en(hs_en),
    .int_osc_ready(int_rdy), .hs_osc_ready(hs_rdy)
  );

  // 100 MHz system clock; oscillator edges never land on integer times
  initial begin sys_clk = 0; forever #5 sys_clk = ~sys_clk; end
  initial begin int_clk = 0; #1.3; forever #3.5 int_clk = ~int_clk; end
  initial begin hs_clk = 0; #0.7; forever #2 hs_clk = ~hs_clk; end

  // ---------------- reference model ----------------
  logic [7:0] m_reg;
  logic [1:0] m_snap_i, m_snap_h;
  logic       m_s1_i, m_s2_i, m_s1_h, m_s2_h;
  int         m_edg_i, m_edg_h;
  wire        m_gate_i = rst_n && m_reg[2];
  wire        m_gate_h = rst_n && m_reg[0];
  wire [31:0] len_i = 32'd8   << (3 - m_snap_i);
  wire [31:0] len_h = 32'd128 << (3 - m_snap_h);
  wire        ordy_i = m_gate_i && (m_edg_i >= int'(len_i) + 2);
  wire        ordy_h = m_gate_h && (m_edg_h >= int'(len_h) + 2);

  always @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= 8'h04; m_snap_i <= 0; m_snap_h <= 0;
      m_s1_i <= 0; m_s2_i <= 0; m_s1_h <= 0; m_s2_h <= 0;
    end else begin
      if (wr_en) m_reg <= wdata & 8'hF5;
      if (!m_reg[2]) m_snap_i <= m_reg[7:6];
      if (!m_reg[0]) m_snap_h <= m_reg[5:4];
      m_s1_i <= m_reg[2] ? ordy_i : 1'b0;
      m_s2_i <= m_reg[2] ? m_s1_i : 1'b0;
      m_s1_h <= m_reg[0] ? ordy_h : 1'b0;
      m_s2_h <= m_reg[0] ? m_s1_h : 1'b0;
    end
  end

  always @(posedge int_clk or negedge m_gate_i)
    if (!m_gate_i) m_edg_i <= 0; else if (m_edg_i < 100000) m_edg_i <= m_edg_i + 1;
  always @(posedge hs_clk or negedge m_gate_h)
    if (!m_gate_h) m_edg_h <= 0; else if (m_edg_h < 100000) m_edg_h <= m_edg_h + 1;

  // ---------------- checking ----------------
  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge sys_clk) begin
    if (rst_n && !done) begin
      chk("R2", rdata, m_reg);
      chk("R2", {6'b0, int_en, hs_en}, {6'b0, m_reg[2], m_reg[0]});
      chk(cur_req, {7'b0, int_rdy}, {7'b0, m_s2_i && m_reg[2]});
      chk(cur_req, {7'b0, hs_rdy},  {7'b0, m_s2_h && m_reg[0]});
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge sys_clk);
    wr_en = 1; wdata = v; ctl = v;
    @(negedge sys_clk);
    wr_en = 0; wdata = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wdata = 0; ctl = 8'h04;
    run(5);
    chk("R1", rdata, 8'h04);
    chk("R1", {6'b0, int_rdy, hs_rdy}, 8'h00);
    #2 rst_n = 1;

    // R8: internal wait of 64 starts at reset release
    cur_req = "R8";
    run(30); chk("R8", {7'b0, int_rdy}, 8'h00);
    run(30); chk("R8", {7'b0, int_rdy}, 8'h01);

    // R6: turning off drops ready on the storing edge
    cur_req = "R6";
    wr(8'h00); chk("R6", {7'b0, int_rdy}, 8'h00);

    // R3: all internal selector codes
    cur_req = "R3";
    for (int s = 3; s >= 0; s--) begin
      int n;
      n = 8 << (3 - s);
      wr(8'(s << 6));
      wr(8'(s << 6) | 8'h04);
      run(2); chk("R3", {7'b0, int_rdy}, 8'h00);
      run((n + 2) * 7 / 10 + 5); chk("R3", {7'b0, int_rdy}, 8'h01);
    end

    // R4: all high-speed selector codes, internal stays ready (R9)
    cur_req = "R4";
    for (int s = 3; s >= 0; s--) begin
      int n;
      n = 128 << (3 - s);
      wr(8'(s << 4) | 8'h04);
      wr(8'(s << 4) | 8'h05);
      run((n + 2) * 4 / 10 - 8); chk("R4", {7'b0, hs_rdy}, 8'h00);
      chk("R9", {7'b0, int_rdy}, 8'h01);
      run(14); chk("R4", {7'b0, hs_rdy}, 8'h01);
    end

    // R7: selector change mid-count keeps the 1024 wait
    cur_req = "R7";
    wr(8'h04); wr(8'h05);
    run(20); wr(8'h35);
    run(60); chk("R7", {7'b0, hs_rdy}, 8'h00);
    run(360); chk("R7", {7'b0, hs_rdy}, 8'h01);
    wr(8'h34); wr(8'h35);
    run(60); chk("R7", {7'b0, hs_rdy}, 8'h01);

    // R6: one-cycle off restarts the full 128 wait
    cur_req = "R6";
    wr(8'h34); wr(8'h35);
    run(2);  chk("R6", {7'b0, hs_rdy}, 8'h00);
    run(40); chk("R6", {7'b0, hs_rdy}, 8'h00);
    run(25); chk("R6", {7'b0, hs_rdy}, 8'h01);

    // R9: switching the internal oscillator leaves high-speed alone
    cur_req = "R9";
    wr(8'hF1); chk("R9", {7'b0, int_rdy}, 8'h00); chk("R9", {7'b0, hs_rdy}, 8'h01);
    wr(8'hF5); run(20); chk("R9", {7'b0, hs_rdy}, 8'h01);

    // R7: selector written together with the enable is not used yet
    cur_req = "R7";
    wr(8'hF4); wr(8'hC5);
    run(60); chk("R7", {7'b0, hs_rdy}, 8'h01);
    chk("R2", rdata, 8'hC5);
    run(10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule